// File: doc/BRIEF.md
# Probe Fast Data Handshake

This block sits between a debug probe's serial scan port and a processor that reads or writes a small window of debug memory. When the processor accesses that window, the access is held pending and the processor stalls. The probe then serves the access through one scan chain. The chain is a 1-bit request/flag cell joined to a 32-bit data word. A single scan reports whether the access can be served. If the probe asks for completion and the access is servable, the scan also finishes it: a processor load receives the shifted-in word, and a processor store has its data shifted out to the probe.

The access tracker is a three-state machine. State IDLE means no access is pending. PEND means the processor is stalled. DONE asserts ready for exactly one cycle. The transitions are named as follows. ACCEPT (IDLE to PEND) fires when a request arrives. COMPLETE (PEND to DONE) fires on an update that asks for and is granted completion. ABANDON (PEND to IDLE) fires if the request is withdrawn. RETIRE (DONE to IDLE) always follows one cycle after COMPLETE.

The scan controls capture_en, shift_en and update_en are single-cycle strobes in the block's clock domain, with at most one high in a cycle. The processor holds req, addr, we and wdata steady from the moment it raises req until it sees ready.

Top module: `fd_probe_xfer`

## Requirements
- R1: After reset, ready is 0, tdo is 0 and no access is pending.
- R2: A request seen in IDLE makes the access pending. Ready stays 0 until that access is completed.
- R3: The chain is 33 bits, shifted toward tdo. Bit 0 is the request/flag cell and is nearest tdo, so it leaves first. tdi enters at bit 32. After 33 shifts, the first bit sent is the request bit and the next 32 bits form the data word, least significant first.
- R4: At capture, the flag cell loads 1 exactly when an access is pending and its address lies in 0xFF200000 to 0xFF20000F inclusive. Otherwise it loads 0.
- R5: At capture, the data field loads the processor's write data when the flag is 1 and the access is a store. In every other case it loads zero.
- R6: An update whose request bit is 0, following a capture that loaded flag 1, makes ready 1 in the cycle after the update. Ready falls back to 0 one cycle later.
- R7: On a completed load, rdata equals the 32-bit word shifted in by that scan while ready is 1.
- R8: An update with request bit 1, or one that follows a capture whose flag was 0, completes nothing. The access stays pending, so a later capture again loads the same flag.
- R9: Dropping req while pending returns the block to IDLE. A later capture then loads flag 0.
- R10: After a completion the block returns to IDLE, and a capture then loads flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_en | input | 1 | Capture strobe for the chain |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in from the probe |
| tdo | output | 1 | Serial data out, the chain's bit 0 |
| req | input | 1 | Processor access request into the window |
| addr | input | 32 | Processor access address |
| we | input | 1 | 1 for store, 0 for load |
| wdata | input | 32 | Processor store data |
| rdata | output | 32 | Load data delivered on completion |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a pending access that survives several full scans and is then abandoned, because the flag must stay set across scans that do not complete. The stimulus sweeps addresses from just below to just above the window, in both directions of access and with both request-bit values. Every scan that does not complete is followed by a second scan, which confirms that the access is still pending. Withdrawing the request is then followed by a third scan, which confirms a return to idle. Completed accesses get the same idle check after retirement.

// File: rtl/fd_pkg.sv
package fd_pkg;
    typedef enum logic [1:0] {
        FD_IDLE = 2'd0,
        FD_PEND = 2'd1,
        FD_DONE = 2'd2
    } fd_state_e;
endpackage

// File: rtl/fd_window_chk.sv
module fd_window_chk #(
    parameter int          AW   = 32,
    parameter logic [31:0] BASE = 32'hFF20_0000,
    parameter int          SPAN = 16
) (
    input  logic [AW-1:0] addr,
    output logic          in_win
);
    localparam logic [AW-1:0] LO = AW'(BASE);
    localparam logic [AW-1:0] HI = AW'(BASE + 32'(SPAN) - 32'd1);

    always_comb begin
        in_win = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/fd_scan_chain.sv
module fd_scan_chain #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          cap_flag,
    input  logic [DW-1:0] cap_data,
    input  logic          tdi,
    output logic          tdo,
    output logic          req_bit,
    output logic [DW-1:0] data_out
);
    localparam int CW = DW + 1;

    logic [CW-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (capture_en) begin
            chain_q <= {cap_data, cap_flag};
        end else if (shift_en) begin
            chain_q <= {tdi, chain_q[CW-1:1]};
        end
    end

    always_comb begin
        tdo      = chain_q[0];
        req_bit  = chain_q[0];
        data_out = chain_q[CW-1:1];
    end
endmodule

// File: rtl/fd_access_fsm.sv
module fd_access_fsm
    import fd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      complete,
    output fd_state_e state,
    output logic      pending,
    output logic      ready
);
    fd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FD_IDLE: if (req) state_d = FD_PEND;
            FD_PEND: begin
                if (!req)          state_d = FD_IDLE;
                else if (complete) state_d = FD_DONE;
            end
            FD_DONE: state_d = FD_IDLE;
            default: state_d = FD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            FD_IDLE: ;
            FD_PEND: pending = 1'b1;
            FD_DONE: ready   = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/fd_probe_xfer.sv
module fd_probe_xfer
    import fd_pkg::*;
#(
    parameter int          AW   = 32,
    parameter int          DW   = 32,
    parameter logic [31:0] BASE = 32'hFF20_0000,
    parameter int          SPAN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          update_en,
    input  logic          tdi,
    output logic          tdo,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready
);
    logic          in_win;
    logic          pending;
    logic          req_bit;
    logic [DW-1:0] data_out;
    logic          cap_ok_q;
    logic          cap_flag;
    logic [DW-1:0] cap_data;
    logic          complete;
    logic [DW-1:0] rdata_q;
    fd_state_e     state;

    fd_window_chk #(.AW(AW), .BASE(BASE), .SPAN(SPAN)) win_i (
        .addr   (addr),
        .in_win (in_win)
    );

    always_comb begin
        cap_flag = pending && in_win;
        cap_data = (cap_flag && we) ? wdata : '0;
        complete = update_en && !capture_en && !shift_en
                   && !req_bit && cap_ok_q && pending && req;
    end

    fd_scan_chain #(.DW(DW)) chain_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .cap_flag   (cap_flag),
        .cap_data   (cap_data),
        .tdi        (tdi),
        .tdo        (tdo),
        .req_bit    (req_bit),
        .data_out   (data_out)
    );

    fd_access_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .complete (complete),
        .state    (state),
        .pending  (pending),
        .ready    (ready)
    );

    // Captured grant: cleared whenever no access is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)          cap_ok_q <= 1'b0;
        else if (capture_en) cap_ok_q <= cap_flag;
        else if (!pending)   cap_ok_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (complete && !we)  rdata_q <= data_out;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/fd_probe_xfer_chk.sv
module fd_probe_xfer_chk #(
    parameter int          AW   = 32,
    parameter logic [31:0] BASE = 32'hFF20_0000,
    parameter int          SPAN = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          capture_en,
    input logic          update_en,
    input logic          tdo,
    input logic          req,
    input logic [AW-1:0] addr,
    input logic          ready,
    input logic          pending
);
    localparam logic [AW-1:0] LO = AW'(BASE);
    localparam logic [AW-1:0] HI = AW'(BASE + 32'(SPAN) - 32'd1);

    logic legal;
    assign legal = (addr >= LO) && (addr <= HI);

    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_ready_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(update_en));

    p_flag_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (tdo == ($past(pending) && $past(legal))));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && req && !update_en) |=> pending);

    p_ready_from_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($past(pending) && $past(legal)));

    p_abandon_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !req) |=> !pending && !ready);
endmodule

bind fd_probe_xfer fd_probe_xfer_chk #(.AW(AW), .BASE(BASE), .SPAN(SPAN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .update_en  (update_en),
    .tdo        (tdo),
    .req        (req),
    .addr       (addr),
    .ready      (ready),
    .pending    (pending)
);

// File: tb/fd_probe_xfer_tb_top.sv
module fd_probe_xfer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        req = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0, rdata;
    logic        ready;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fd_probe_xfer dut_i (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo), .req(req), .addr(addr),
        .we(we), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Full scan: capture, 33 shifts (request bit first, then data LSB first), update.
    task automatic scan(input logic rbit, input logic [31:0] din, output logic [32:0] dout);
        logic [32:0] vin;
        vin = {din, rbit};
        @(negedge clk) capture_en = 1'b1;
        @(negedge clk) capture_en = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < 33; i++) begin
            tdi     = vin[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_en  = 1'b0;
        update_en = 1'b1;
        @(negedge clk) update_en = 1'b0;
    endtask

    initial begin
        logic [32:0] so;
        logic        ok;
        logic [31:0] din, wd, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, ready}, 32'd0);
        check("R1 tdo after reset", {31'd0, tdo}, 32'd0);
        scan(1'b0, 32'h1234_5678, so);
        check("R1 idle capture flag", {31'd0, so[0]}, 32'd0);
        check("R1 no ready when idle", {31'd0, ready}, 32'd0);

        for (int k = -2; k < 18; k++) begin
            for (int w = 0; w < 2; w++) begin
                for (int r = 0; r < 2; r++) begin
                    a   = 32'hFF20_0000 + 32'(k);
                    ok  = (k >= 0) && (k <= 15);
                    wd  = 32'hA500_0000 ^ (32'(k + 5) * 32'h0101_0101) ^ 32'(w * 32'h0000_F00F);
                    din = 32'h3C00_0000 ^ (32'(k + 7) * 32'h0011_0203) ^ 32'(r);
                    @(negedge clk);
                    req = 1'b1; addr = a; we = w[0]; wdata = wd;
                    @(negedge clk);
                    check("R2 stalled while pending", {31'd0, ready}, 32'd0);
                    scan(r[0], din, so);
                    check("R3 R4 flag bit", {31'd0, so[0]}, {31'd0, ok});
                    check("R3 R5 captured data", so[32:1], (ok && w == 1) ? wd : 32'd0);
                    check("R6 ready after update", {31'd0, ready}, {31'd0, ok && r == 0});
                    if (ok && r == 0) begin
                        if (w == 0) check("R7 load data", rdata, din);
                        req = 1'b0;
                        @(negedge clk);
                        check("R6 ready one cycle", {31'd0, ready}, 32'd0);
                        scan(1'b0, din, so);
                        check("R10 idle after retire", {31'd0, so[0]}, 32'd0);
                    end else begin
                        repeat (3) @(negedge clk);
                        check("R8 no completion", {31'd0, ready}, 32'd0);
                        scan(1'b1, din, so);
                        check("R8 still pending", {31'd0, so[0]}, {31'd0, ok});
                        check("R8 still stalled", {31'd0, ready}, 32'd0);
                        req = 1'b0;
                        @(negedge clk);
                        @(negedge clk);
                        scan(1'b0, din, so);
                        check("R9 abandon to idle", {31'd0, so[0]}, 32'd0);
                        check("R9 no ready after abandon", {31'd0, ready}, 32'd0);
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule